// File: doc/BRIEF.md
# Programmable Defect Condition Detector

This block sits beside one processor subsystem and watches a wide bus of tapped status events (snoop seen, first-level cache hit, I/O request, low-power flag and similar). A routing stage narrows the bus to a small set of lanes. A bank of signature slots then tests those lanes against defect conditions that are loaded after manufacture. Each slot holds an enable, a timing mode, a pre/post tag, a window length and four product terms. Each product term has a mask of lanes that must be high and a mask of lanes that must be low.

A slot in concurrent mode fires whenever any of its used terms is true in the current cycle, so it forms a sum of products such as `A | (B & C & D)`. A slot in complex mode remembers each term that has been true since its last clear. It fires once every used term has been seen, so the events may arrive in different cycles. A programmable window drops a partial history that grows too old. When slots fire, the lowest-indexed one is latched into a report that carries the slot index and its pre/post tag. The report is held for a recovery controller until that controller acknowledges it. While a report is pending, configuration writes are refused.

Top module: `defect_watch`

## Requirements
- R1: After reset `match_valid` is 0, every slot is disabled and lane k is routed from tap k. A disabled slot produces no report whatever the taps are.
- R2: A write of kind 5 routes lane `cfg_data[3:0]` from tap `cfg_data[13:8]`. From then on, the previously routed tap has no effect on that lane.
- R3: A term is used when either of its masks is nonzero. A used term is true when every lane in its high mask (`cfg_data[15:0]` of kinds 1 to 4, for terms 0 to 3) is 1 and every lane in its low mask (`cfg_data[31:16]`) is 0. In concurrent mode a slot fires when any used term is true, and the report rises on the clock edge that samples those taps.
- R4: In complex mode (control bit 1) a slot fires when every used term is either true now or has been true since the last clear. All terms true in one cycle also fire the slot.
- R5: In complex mode with window W (control bits 15:8) nonzero, a partial history is erased at the W-th edge after its first term was recorded, unless the slot fires at that edge. W = 0 never erases.
- R6: Reporting a complex slot erases its recorded terms.
- R7: When several slots fire in one cycle, the report names the lowest slot index.
- R8: `match_valid` stays high, with `match_idx` and `match_post` (control bit 2) unchanged, until an edge with `match_ack` high clears it. No new report is latched while one is pending.
- R9: Configuration writes (`cfg_kind` 0 for control, 1 to 4 for terms, 5 for routing) are ignored while `match_valid` is high and take effect otherwise.
- R10: A slot whose enable (control bit 0) is 0 never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| taps | input | 64 | Tapped subsystem status events |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | 3 | Signature slot addressed by the write |
| cfg_kind | input | 3 | 0 control, 1-4 term 0-3, 5 lane routing |
| cfg_data | input | 32 | Configuration word |
| match_ack | input | 1 | Recovery controller accepts the report |
| match_valid | output | 1 | A defect report is pending |
| match_idx | output | 3 | Index of the reported slot |
| match_post | output | 1 | Tag of the reported slot: 1 post-defect, 0 pre-defect |

## Verification
On every cycle the assertions check that a pending report holds its index and tag until it is acknowledged, that an acknowledge clears it, and that a report never appears without a firing slot. They also check that a new report names the lowest slot that fired, and that slot enables cannot change while a write arrives during a pending report. The decoding of the term masks, lane routing, the ordering of complex events, window expiry at exactly the W-th edge, the erasure of history after a report, and the refusal of writes that are observable only through later behaviour can be shown only by the bench's scenarios. Those scenarios program slots and replay tap patterns cycle by cycle.

// File: rtl/dw_pkg.sv
package dw_pkg;

    localparam int TAP_N_DEF  = 64;
    localparam int LANE_N_DEF = 16;
    localparam int SIG_N_DEF  = 8;
    localparam int TERM_N_DEF = 4;
    localparam int WIN_W      = 8;
    localparam int CFG_W      = 32;

    typedef enum logic [2:0] {
        K_CTRL  = 3'd0,
        K_TERM0 = 3'd1,
        K_TERM1 = 3'd2,
        K_TERM2 = 3'd3,
        K_TERM3 = 3'd4,
        K_MAP   = 3'd5
    } cfg_kind_e;

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic             post;
        logic             cplx;
        logic             en;
    } sig_ctrl_t;

    function automatic sig_ctrl_t ctrl_from_word(input logic [CFG_W-1:0] w);
        sig_ctrl_t c;
        c.en   = w[0];
        c.cplx = w[1];
        c.post = w[2];
        c.win  = w[8 +: WIN_W];
        return c;
    endfunction

endpackage

// File: rtl/dw_select.sv
module dw_select #(
    parameter int TAP_N  = dw_pkg::TAP_N_DEF,
    parameter int LANE_N = dw_pkg::LANE_N_DEF,
    localparam int TAP_W  = $clog2(TAP_N),
    localparam int LANE_W = $clog2(LANE_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              map_we,
    input  logic [LANE_W-1:0] map_lane,
    input  logic [TAP_W-1:0]  map_tap,
    input  logic [TAP_N-1:0]  taps,
    output logic [LANE_N-1:0] lanes
);

    logic [TAP_W-1:0] route_q [LANE_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < LANE_N; k++)
                route_q[k] <= TAP_W'(k);
        end else if (map_we) begin
            route_q[map_lane] <= map_tap;
        end
    end

    for (genvar g = 0; g < LANE_N; g++) begin : g_lane
        assign lanes[g] = taps[route_q[g]];
    end

endmodule

// File: rtl/dw_sig_slot.sv
module dw_sig_slot #(
    parameter int LANE_N = dw_pkg::LANE_N_DEF,
    parameter int TERM_N = dw_pkg::TERM_N_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [2:0]              wr_kind,
    input  logic [dw_pkg::CFG_W-1:0] wr_data,
    input  logic [LANE_N-1:0]       lanes,
    input  logic                    taken,
    output logic                    fire,
    output logic                    en,
    output logic                    post
);
    import dw_pkg::*;

    sig_ctrl_t          ctrl_q;
    logic [LANE_N-1:0]  hi_mask [TERM_N];
    logic [LANE_N-1:0]  lo_mask [TERM_N];
    logic [TERM_N-1:0]  used;
    logic [TERM_N-1:0]  now_true;
    logic [TERM_N-1:0]  seen_q;
    logic [WIN_W-1:0]   age_q;
    logic               ctrl_wr;

    assign ctrl_wr = wr_en && (wr_kind == K_CTRL);

    for (genvar t = 0; t < TERM_N; t++) begin : g_term
        always_ff @(posedge clk) begin
            if (rst) begin
                hi_mask[t] <= '0;
                lo_mask[t] <= '0;
            end else if (wr_en && wr_kind == 3'(t + 1)) begin
                hi_mask[t] <= wr_data[LANE_N-1:0];
                lo_mask[t] <= wr_data[LANE_N +: LANE_N];
            end
        end
        assign used[t]     = |(hi_mask[t] | lo_mask[t]);
        assign now_true[t] = used[t]
                          && ((lanes & hi_mask[t]) == hi_mask[t])
                          && ((~lanes & lo_mask[t]) == lo_mask[t]);
    end

    always_comb begin
        if (!ctrl_q.en)
            fire = 1'b0;
        else if (ctrl_q.cplx)
            fire = (|used) && (&(~used | seen_q | now_true));
        else
            fire = |now_true;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            seen_q <= '0;
            age_q  <= '0;
        end else begin
            if (ctrl_wr)
                ctrl_q <= ctrl_from_word(wr_data);
            if (ctrl_wr || !ctrl_q.en || !ctrl_q.cplx || taken) begin
                seen_q <= '0;
                age_q  <= '0;
            end else if (seen_q == '0) begin
                seen_q <= now_true;
                age_q  <= '0;
            end else if (ctrl_q.win != '0 && age_q == ctrl_q.win - WIN_W'(1)) begin
                seen_q <= '0;
                age_q  <= '0;
            end else begin
                seen_q <= seen_q | now_true;
                age_q  <= age_q + WIN_W'(1);
            end
        end
    end

    assign en   = ctrl_q.en;
    assign post = ctrl_q.post;

endmodule

// File: rtl/dw_prio.sv
module dw_prio #(
    parameter int N = dw_pkg::SIG_N_DEF,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i])
                idx = W'(i);
        end
    end

endmodule

// File: rtl/defect_watch.sv
module defect_watch #(
    parameter int TAP_N  = dw_pkg::TAP_N_DEF,
    parameter int LANE_N = dw_pkg::LANE_N_DEF,
    parameter int SIG_N  = dw_pkg::SIG_N_DEF,
    parameter int TERM_N = dw_pkg::TERM_N_DEF,
    localparam int TAP_W  = $clog2(TAP_N),
    localparam int LANE_W = $clog2(LANE_N),
    localparam int SIG_W  = $clog2(SIG_N)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [TAP_N-1:0]         taps,
    input  logic                     cfg_we,
    input  logic [SIG_W-1:0]         cfg_slot,
    input  logic [2:0]               cfg_kind,
    input  logic [dw_pkg::CFG_W-1:0] cfg_data,
    input  logic                     match_ack,
    output logic                     match_valid,
    output logic [SIG_W-1:0]         match_idx,
    output logic                     match_post
);
    import dw_pkg::*;

    logic              cfg_ok;
    logic              map_we;
    logic [LANE_N-1:0] lanes;
    logic [SIG_N-1:0]  hits;
    logic [SIG_N-1:0]  en_vec;
    logic [SIG_N-1:0]  post_vec;
    logic [SIG_N-1:0]  taken;
    logic              any_hit;
    logic [SIG_W-1:0]  win_idx;
    logic              capture;

    assign cfg_ok = cfg_we && !match_valid;
    assign map_we = cfg_ok && (cfg_kind == K_MAP);

    dw_select #(.TAP_N(TAP_N), .LANE_N(LANE_N)) u_select (
        .clk      (clk),
        .rst      (rst),
        .map_we   (map_we),
        .map_lane (cfg_data[LANE_W-1:0]),
        .map_tap  (cfg_data[8 +: TAP_W]),
        .taps     (taps),
        .lanes    (lanes)
    );

    for (genvar s = 0; s < SIG_N; s++) begin : g_slot
        dw_sig_slot #(.LANE_N(LANE_N), .TERM_N(TERM_N)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (cfg_ok && cfg_kind != K_MAP && cfg_slot == SIG_W'(s)),
            .wr_kind (cfg_kind),
            .wr_data (cfg_data),
            .lanes   (lanes),
            .taken   (taken[s]),
            .fire    (hits[s]),
            .en      (en_vec[s]),
            .post    (post_vec[s])
        );
        assign taken[s] = capture && (win_idx == SIG_W'(s));
    end

    dw_prio #(.N(SIG_N)) u_prio (
        .req (hits),
        .any (any_hit),
        .idx (win_idx)
    );

    assign capture = any_hit && !match_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            match_valid <= 1'b0;
            match_idx   <= '0;
            match_post  <= 1'b0;
        end else if (match_valid) begin
            if (match_ack)
                match_valid <= 1'b0;
        end else if (capture) begin
            match_valid <= 1'b1;
            match_idx   <= win_idx;
            match_post  <= post_vec[win_idx];
        end
    end

endmodule

// File: rtl/dw_checker.sv
module dw_checker #(
    parameter int SIG_N = dw_pkg::SIG_N_DEF,
    localparam int SIG_W = $clog2(SIG_N)
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic             match_ack,
    input logic             match_valid,
    input logic [SIG_W-1:0] match_idx,
    input logic             match_post,
    input logic [SIG_N-1:0] hits,
    input logic [SIG_N-1:0] en_vec
);

    localparam logic [SIG_N-1:0] ONE = SIG_N'(1);
    logic [SIG_N-1:0] below_mask;
    assign below_mask = (ONE << match_idx) - ONE;

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> !match_valid);

    assert_no_phantom_R3: assert property (@(posedge clk) disable iff (rst)
        (!match_valid && hits == '0) |=> !match_valid);

    assert_lowest_wins_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(match_valid) |->
            ((($past(hits) >> match_idx) & ONE) == ONE) && (($past(hits) & below_mask) == '0));

    assert_report_held_R8: assert property (@(posedge clk) disable iff (rst)
        (match_valid && !match_ack) |=> (match_valid && $stable(match_idx) && $stable(match_post)));

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (match_valid && match_ack) |=> !match_valid);

    assert_locked_cfg_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && match_valid) |=> $stable(en_vec));

endmodule

bind defect_watch dw_checker #(.SIG_N(SIG_N)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .match_ack   (match_ack),
    .match_valid (match_valid),
    .match_idx   (match_idx),
    .match_post  (match_post),
    .hits        (hits),
    .en_vec      (en_vec)
);

// File: tb/defect_watch_tb.sv
`timescale 1ns/1ps
module defect_watch_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] taps;
    logic        cfg_we;
    logic [2:0]  cfg_slot;
    logic [2:0]  cfg_kind;
    logic [31:0] cfg_data;
    logic        match_ack;
    logic        match_valid;
    logic [2:0]  match_idx;
    logic        match_post;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    defect_watch u_dut (
        .clk         (clk),
        .rst         (rst),
        .taps        (taps),
        .cfg_we      (cfg_we),
        .cfg_slot    (cfg_slot),
        .cfg_kind    (cfg_kind),
        .cfg_data    (cfg_data),
        .match_ack   (match_ack),
        .match_valid (match_valid),
        .match_idx   (match_idx),
        .match_post  (match_post)
    );

    // entry: {taps, expected valid, expected idx, expected post}
    localparam int NV = 28;
    localparam logic [68:0] VEC [NV] = '{
        {64'h0,          1'b0, 3'd0, 1'b0}, // 0  R3 idle
        {64'h1,          1'b1, 3'd0, 1'b0}, // 1  R3 single-lane term
        {64'h6,          1'b0, 3'd0, 1'b0}, // 2  R3 partial product
        {64'hE,          1'b1, 3'd0, 1'b0}, // 3  R3 full product
        {64'h10,         1'b1, 3'd1, 1'b1}, // 4  R3 high lane with low lane clear
        {64'h30,         1'b0, 3'd0, 1'b0}, // 5  R3 low-mask lane set blocks
        {64'h8000,       1'b0, 3'd0, 1'b0}, // 6  R2 old tap rerouted away
        {64'h100_0000_0000, 1'b1, 3'd3, 1'b1}, // 7  R2 new tap 40
        {64'h100,        1'b0, 3'd0, 1'b0}, // 8  R10 disabled slot
        {64'h11,         1'b1, 3'd0, 1'b0}, // 9  R7 slots 0 and 1 together
        {64'h40,         1'b0, 3'd0, 1'b0}, // 10 R4 first event
        {64'h0,          1'b0, 3'd0, 1'b0}, // 11
        {64'h0,          1'b0, 3'd0, 1'b0}, // 12
        {64'h80,         1'b1, 3'd2, 1'b0}, // 13 R4 R5 second event at edge W
        {64'h40,         1'b0, 3'd0, 1'b0}, // 14 R5 first event
        {64'h0,          1'b0, 3'd0, 1'b0}, // 15
        {64'h0,          1'b0, 3'd0, 1'b0}, // 16
        {64'h0,          1'b0, 3'd0, 1'b0}, // 17 R5 history erased here
        {64'h80,         1'b0, 3'd0, 1'b0}, // 18 R5 too late
        {64'h40,         1'b1, 3'd2, 1'b0}, // 19 R4 reverse order
        {64'hC0,         1'b1, 3'd2, 1'b0}, // 20 R4 same cycle
        {64'h80,         1'b0, 3'd0, 1'b0}, // 21 R6 history gone after report
        {64'h200,        1'b0, 3'd0, 1'b0}, // 22 R5 window zero, first event
        {64'h0,          1'b0, 3'd0, 1'b0}, // 23
        {64'h0,          1'b0, 3'd0, 1'b0}, // 24
        {64'h0,          1'b0, 3'd0, 1'b0}, // 25
        {64'h0,          1'b0, 3'd0, 1'b0}, // 26
        {64'h400,        1'b1, 3'd5, 1'b0}  // 27 R5 no expiry with W=0
    };

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic chk(input string req, input logic ev, input logic [2:0] ei, input logic ep);
        logic ok;
        total++;
        ok = (match_valid === ev) && (!ev || (match_idx === ei && match_post === ep));
        if (!ok) begin
            bad++;
            $display("FAIL %s: got valid=%0b idx=%0d post=%0b, expected valid=%0b idx=%0d post=%0b",
                     req, match_valid, match_idx, match_post, ev, ei, ep);
        end
    endtask

    task automatic step(input logic [63:0] t);
        taps = t;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ack();
        match_ack = 1'b1;
        taps = '0;
        @(posedge clk);
        @(negedge clk);
        match_ack = 1'b0;
    endtask

    task automatic cfg(input logic [2:0] slot, input logic [2:0] kind, input logic [31:0] data);
        cfg_we = 1'b1; cfg_slot = slot; cfg_kind = kind; cfg_data = data;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got no finish, expected finish");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; taps = '0; cfg_we = 1'b0; cfg_slot = '0; cfg_kind = '0;
        cfg_data = '0; match_ack = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 in reset", 1'b0, 3'd0, 1'b0);
        rst = 1'b0;
        step(64'h0);
        chk("R1 after reset", 1'b0, 3'd0, 1'b0);
        step('1);
        chk("R1 all slots disabled", 1'b0, 3'd0, 1'b0);
        step('0);

        cfg(3'd0, 3'd5, {16'h0, 2'b0, 6'd40, 4'h0, 4'd15}); // lane 15 <- tap 40
        cfg(3'd0, 3'd1, 32'h0000_0001);
        cfg(3'd0, 3'd2, 32'h0000_000E);
        cfg(3'd0, 3'd0, 32'h0000_0001);
        cfg(3'd1, 3'd1, 32'h0020_0010);
        cfg(3'd1, 3'd0, 32'h0000_0005);
        cfg(3'd2, 3'd1, 32'h0000_0040);
        cfg(3'd2, 3'd2, 32'h0000_0080);
        cfg(3'd2, 3'd0, 32'h0000_0303);
        cfg(3'd3, 3'd1, 32'h0000_8000);
        cfg(3'd3, 3'd0, 32'h0000_0005);
        cfg(3'd4, 3'd1, 32'h0000_0100);
        cfg(3'd5, 3'd1, 32'h0000_0200);
        cfg(3'd5, 3'd2, 32'h0000_0400);
        cfg(3'd5, 3'd0, 32'h0000_0003);

        for (int v = 0; v < NV; v++) begin
            step(VEC[v][68:5]);
            chk($sformatf("vector %0d", v), VEC[v][4], VEC[v][3:1], VEC[v][0]);
            if (VEC[v][4]) ack();
        end

        // R8 hold and blocking, R9 refusal while pending
        step(64'h1);
        chk("R8 report sig0", 1'b1, 3'd0, 1'b0);
        cfg_we = 1'b1; cfg_slot = 3'd0; cfg_kind = 3'd0; cfg_data = 32'h0;
        step(64'h10);
        cfg_we = 1'b0;
        chk("R8 held while sig1 fires", 1'b1, 3'd0, 1'b0);
        match_ack = 1'b1;
        step(64'h10);
        match_ack = 1'b0;
        chk("R8 ack clears", 1'b0, 3'd0, 1'b0);
        step(64'h10);
        chk("R8 next report after ack", 1'b1, 3'd1, 1'b1);
        ack();
        step(64'h1);
        chk("R9 write during pending ignored", 1'b1, 3'd0, 1'b0);
        ack();
        cfg(3'd0, 3'd0, 32'h0);
        step(64'h1);
        chk("R9 write when idle applies", 1'b0, 3'd0, 1'b0);
        step(64'h0);

        summary();
        $finish;
    end

endmodule